// File: doc/BRIEF.md
# Sector Protection Tuple Engine

This block sits in a storage data path and handles the 8-byte protection tuple that follows each logical sector. Data arrives as a byte stream with a ready/valid pair on the input side. Each sector is a fixed number of data bytes (`SECT_BYTES`). After the data comes the metadata area. The tuple occupies the first eight metadata bytes. Any further metadata bytes (`META_EXTRA`) are carried along unchanged. Each tuple holds three fields:
- a 16-bit guard, which is a CRC over the sector data,
- a 16-bit application tag,
- a 32-bit reference tag.

The block has three operating modes:
- **Pass**: the tuple stays in the stream and is checked.
- **Strip**: the tuple is checked and then removed from the output.
- **Insert**: the input carries no tuple. The block builds one after each sector's data and holds the input off while it emits the eight tuple bytes.

One pulse per checked sector reports a guard mismatch and a reference mismatch. Either tag field holding its all-ones value turns checking off for that sector. The protection type selects how the expected reference tag is formed. A `start` pulse marks the start of a command: it reloads the reference seed and realigns the engine to a sector boundary.

The engine is a four-state machine:

| State | What it does | Next state |
|-------|--------------|------------|
| `ST_DATA` | Forwards data bytes and feeds the CRC. | After `SECT_BYTES` accepted bytes: `ST_TUP_GEN` in insert mode, otherwise `ST_TUP_CHK`. |
| `ST_TUP_CHK` | Collects the received tuple, forwards it unless stripping, and on its last byte issues the check result. | After 8 bytes: `ST_META` if `META_EXTRA` > 0, otherwise `ST_DATA`. |
| `ST_TUP_GEN` | Emits the computed tuple, one byte per cycle, with the input stalled. | After 8 cycles: `ST_META` if `META_EXTRA` > 0, otherwise `ST_DATA`. |
| `ST_META` | Forwards the remaining metadata bytes. | After `META_EXTRA` bytes: `ST_DATA`. |

From any state, `start` forces `ST_DATA`.

Top module: `sector_prot_engine`

## Requirements
- R1: After reset, out_valid and err_valid are low and in_ready is high.
- R2: In pass mode (cfg_mode 0 or 3), every accepted byte appears unchanged on out_data with out_valid high one cycle after acceptance. The sector layout is SECT_BYTES data bytes, then 8 tuple bytes, then META_EXTRA bytes.
- R3: The guard is a CRC-16 over the sector's data bytes in arrival order. It uses polynomial 0x8BB7, initial value 0, MSB first, with no reflection and no final XOR. The tuple is sent most significant byte first, in field order guard, application tag, reference tag.
- R4: In pass and strip modes, err_valid pulses for one cycle starting one cycle after the last tuple byte is accepted. err_guard and err_ref are low whenever err_valid is low.
- R5: err_guard is set when the received guard differs from the CRC computed over that sector's data.
- R6: The expected reference tag depends on cfg_type:
  - cfg_type 1: the seed loaded by start plus the number of sectors completed since start.
  - cfg_type 2: cfg_ref for every sector.
  - cfg_type 0 or 3: the reference tag is never checked.
  
  err_ref is set on a mismatch with the expected value.
- R7: A received application tag of 0xFFFF suppresses both flags for that sector. Any other application tag value is never compared.
- R8: A received reference tag of 0xFFFFFFFF suppresses both flags for that sector.
- R9: In strip mode (cfg_mode 2), the tuple bytes are checked as in R4–R8 but do not appear on the output. Data and extra metadata bytes are still forwarded.
- R10: In insert mode (cfg_mode 1), the input carries data then extra metadata. The output carries data, then a tuple, then the extra metadata. The tuple holds the computed guard, cfg_app, and the expected reference from R6 (cfg_ref for types 0, 2 and 3). in_ready is low for exactly 8 cycles per sector, and err_valid never pulses.
- R11: A start pulse reloads the type-1 seed from cfg_ref, drops any partially received sector, and treats the next accepted byte as the first data byte of a sector. in_ready is low during the pulse.
- R12: In every mode, the META_EXTRA bytes after the tuple pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command start: reload reference seed, realign to sector start |
| cfg_mode | input | 2 | 0/3 pass, 1 insert, 2 strip |
| cfg_type | input | 2 | Protection type 1, 2, 3 (0 = no reference check) |
| cfg_ref | input | 32 | Reference seed (type 1) or fixed reference (types 2/3 and insert) |
| cfg_app | input | 16 | Application tag written in insert mode |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| err_valid | output | 1 | Per-sector check result valid |
| err_guard | output | 1 | Guard mismatch |
| err_ref | output | 1 | Reference tag mismatch |

## Verification
The bench builds the engine with SECT_BYTES = 4 and META_EXTRA = 2. A full sector is then only 14 bytes, so dozens of sectors fit in a short run. The sweep covers every mode combined with every protection type, including both escape values and deliberate corruption of the guard and reference fields. Because sectors are short, the bench can also cover:
- a type-1 reference tag that has stepped through many sectors,
- the extra-metadata state, which is entered on every sector,
- a start pulse arriving in the middle of a sector.

Expected guards come from a bench-side bit-serial CRC.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int TUPLE_BYTES = 8;
    localparam logic [15:0] GUARD_POLY = 16'h8BB7;

    typedef enum logic [1:0] {
        ST_DATA,
        ST_TUP_CHK,
        ST_TUP_GEN,
        ST_META
    } sp_state_t;

    localparam logic [1:0] MODE_INSERT = 2'd1;
    localparam logic [1:0] MODE_STRIP  = 2'd2;

    // One byte of the guard CRC, MSB first, no reflection.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ GUARD_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/sp_guard_crc.sv
module sp_guard_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sp_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/sp_ref_track.sv
module sp_ref_track #(
    parameter int REF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REF_W-1:0] load_val,
    input  logic             adv,
    output logic [REF_W-1:0] ref_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ref_val <= '0;
        else if (load) ref_val <= load_val;
        else if (adv)  ref_val <= ref_val + REF_W'(1);
    end
endmodule

// File: rtl/sector_prot_engine.sv
module sector_prot_engine #(
    parameter int SECT_BYTES = 512,
    parameter int META_EXTRA = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_type,
    input  logic [31:0] cfg_ref,
    input  logic [15:0] cfg_app,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        err_valid,
    output logic        err_guard,
    output logic        err_ref
);
    import sp_pkg::*;

    localparam bit HAS_META = (META_EXTRA > 0);
    localparam int META_LIM = HAS_META ? META_EXTRA : 1;
    localparam int MAX_A    = (SECT_BYTES > TUPLE_BYTES) ? SECT_BYTES : TUPLE_BYTES;
    localparam int MAX_LIM  = (MAX_A > META_LIM) ? MAX_A : META_LIM;
    localparam int CW       = $clog2(MAX_LIM);

    sp_state_t       state, state_nx;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   lim_m1;
    logic            beat, last, sec_end;
    logic            is_ins, is_strip;
    logic [15:0]     crc_val;
    logic [31:0]     trk_ref, exp_ref;
    logic [55:0]     tup_sh;
    logic [63:0]     rx_tuple, gen_tuple, gen_shift;
    logic            esc, chk_ref, bad_g, bad_r;

    assign is_ins   = (cfg_mode == MODE_INSERT);
    assign is_strip = (cfg_mode == MODE_STRIP);
    assign in_ready = !start && (state != ST_TUP_GEN);
    assign beat     = !start && ((state == ST_TUP_GEN) || in_valid);

    always_comb begin
        unique case (state)
            ST_DATA:    lim_m1 = CW'(SECT_BYTES - 1);
            ST_TUP_CHK: lim_m1 = CW'(TUPLE_BYTES - 1);
            ST_TUP_GEN: lim_m1 = CW'(TUPLE_BYTES - 1);
            ST_META:    lim_m1 = CW'(META_LIM - 1);
            default:    lim_m1 = '0;
        endcase
    end

    assign last    = (cnt == lim_m1);
    assign sec_end = beat && last && ((state == ST_TUP_CHK) || (state == ST_TUP_GEN));

    sp_guard_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sec_end || start),
        .en    (beat && (state == ST_DATA)),
        .din   (in_data),
        .crc   (crc_val)
    );

    sp_ref_track #(.REF_W(32)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cfg_ref),
        .adv      (sec_end && (cfg_type == 2'd1)),
        .ref_val  (trk_ref)
    );

    assign exp_ref = (cfg_type == 2'd1) ? trk_ref : cfg_ref;

    // Received and generated tuples
    assign rx_tuple  = {tup_sh, in_data};
    assign gen_tuple = {crc_val, cfg_app, exp_ref};
    assign gen_shift = gen_tuple << {cnt, 3'b000};

    assign esc     = (rx_tuple[47:32] == 16'hFFFF) || (rx_tuple[31:0] == 32'hFFFF_FFFF);
    assign chk_ref = (cfg_type == 2'd1) || (cfg_type == 2'd2);
    assign bad_g   = !esc && (rx_tuple[63:48] != crc_val);
    assign bad_r   = !esc && chk_ref && (rx_tuple[31:0] != exp_ref);

    // Next state
    always_comb begin
        state_nx = state;
        if (beat && last) begin
            unique case (state)
                ST_DATA:    state_nx = is_ins ? ST_TUP_GEN : ST_TUP_CHK;
                ST_TUP_CHK: state_nx = HAS_META ? ST_META : ST_DATA;
                ST_TUP_GEN: state_nx = HAS_META ? ST_META : ST_DATA;
                ST_META:    state_nx = ST_DATA;
                default:    state_nx = ST_DATA;
            endcase
        end
    end

    // State register and position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DATA;
            cnt   <= '0;
        end else if (start) begin
            state <= ST_DATA;
            cnt   <= '0;
        end else if (beat) begin
            state <= state_nx;
            cnt   <= last ? '0 : cnt + CW'(1);
        end
    end

    // Outputs and tuple capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            err_valid <= 1'b0;
            err_guard <= 1'b0;
            err_ref   <= 1'b0;
            tup_sh    <= '0;
        end else begin
            out_valid <= 1'b0;
            err_valid <= 1'b0;
            err_guard <= 1'b0;
            err_ref   <= 1'b0;
            if (beat) begin
                unique case (state)
                    ST_DATA, ST_META: begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                    end
                    ST_TUP_CHK: begin
                        tup_sh <= rx_tuple[55:0];
                        if (!is_strip) begin
                            out_valid <= 1'b1;
                            out_data  <= in_data;
                        end
                        if (last) begin
                            err_valid <= 1'b1;
                            err_guard <= bad_g;
                            err_ref   <= bad_r;
                        end
                    end
                    ST_TUP_GEN: begin
                        out_valid <= 1'b1;
                        out_data  <= gen_shift[63:56];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sp_prot_checker.sv
module sp_prot_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  cfg_mode,
    input logic [1:0]  cfg_type,
    input logic        in_valid,
    input logic [7:0]  in_data,
    input logic        in_ready,
    input logic        out_valid,
    input logic [7:0]  out_data,
    input logic        err_valid,
    input logic        err_guard,
    input logic        err_ref
);
    // R2: pass mode echoes each accepted byte one cycle later
    a_r2_pass_echo: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd0) && in_valid && in_ready) |=> (out_valid && (out_data == $past(in_data))));

    // R4: flags only qualified by err_valid
    a_r4_flag_qual: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (!err_guard && !err_ref));

    // R6: types 0 and 3 never flag the reference
    a_r6_ref_type: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_ref) |-> ((cfg_type == 2'd1) || (cfg_type == 2'd2)));

    // R10: a stalled input in insert mode always emits a tuple byte
    a_r10_stall_emits: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd1) && !in_ready && !start) |=> out_valid);

    // R10: insert mode issues no check result
    a_r10_no_err_insert: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd1) && ($past(cfg_mode) == 2'd1)) |-> !err_valid);

    // R11: no byte is accepted during a start pulse
    a_r11_start_block: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);
endmodule

bind sector_prot_engine sp_prot_checker u_sp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_mode  (cfg_mode),
    .cfg_type  (cfg_type),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .err_valid (err_valid),
    .err_guard (err_guard),
    .err_ref   (err_ref)
);

// File: tb/sector_prot_engine_bench.sv
module sector_prot_engine_bench;
    localparam int SB = 4;
    localparam int ME = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_type = 2'd1;
    logic [31:0] cfg_ref = 32'd0;
    logic [15:0] cfg_app = 16'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_ready, out_valid, err_valid, err_guard, err_ref;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] obs [0:31];
    int nobs = 0, nerr = 0, nstall = 0;
    logic eg = 1'b0, er = 1'b0;

    always #10 clk = ~clk;

    sector_prot_engine #(.SECT_BYTES(SB), .META_EXTRA(ME)) u_sector_prot_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode), .cfg_type(cfg_type),
        .cfg_ref(cfg_ref), .cfg_app(cfg_app), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .err_valid(err_valid), .err_guard(err_guard), .err_ref(err_ref)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (nobs < 32) obs[nobs] = out_data;
                nobs = nobs + 1;
            end
            if (err_valid) begin
                nerr = nerr + 1;
                eg = err_guard;
                er = err_ref;
            end
            if (!in_ready && !start) nstall = nstall + 1;
        end
    end

    function automatic logic [15:0] crc_of(input logic [31:0] d);
        logic [15:0] c = 16'h0;
        logic [7:0]  b;
        logic        fb;
        for (int k = 0; k < 4; k++) begin
            b = d[31-8*k -: 8];
            for (int i = 7; i >= 0; i--) begin
                fb = c[15] ^ b[i];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h8BB7 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic pulse_start(input logic [31:0] seed);
        @(negedge clk);
        cfg_ref = seed;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Sends one sector in the current mode and checks everything it produces.
    // For insert mode, rt is the expected reference and gd/ap are unused.
    task automatic do_sector(input logic [31:0] dat, input logic [15:0] gd, input logic [15:0] ap,
                             input logic [31:0] rt, input logic [15:0] mt,
                             input bit xg, input bit xr, input string req);
        logic [7:0] exp [0:31];
        int ne = 0;
        logic [63:0] tup;
        bit ins, strp;
        ins  = (cfg_mode == 2'd1);
        strp = (cfg_mode == 2'd2);
        nobs = 0; nerr = 0; nstall = 0; eg = 1'b0; er = 1'b0;
        for (int k = 0; k < 4; k++) begin
            put(dat[31-8*k -: 8]);
            exp[ne] = dat[31-8*k -: 8]; ne++;
        end
        tup = ins ? {crc_of(dat), cfg_app, rt} : {gd, ap, rt};
        for (int k = 0; k < 8; k++) begin
            if (!ins) put(tup[63-8*k -: 8]);
            if (!strp) begin exp[ne] = tup[63-8*k -: 8]; ne++; end
        end
        for (int k = 0; k < 2; k++) begin
            put(mt[15-8*k -: 8]);
            exp[ne] = mt[15-8*k -: 8]; ne++;
        end
        repeat (3) @(negedge clk);
        check(nobs == ne, req, "byte count", nobs, ne);
        begin
            int bad = -1;
            for (int k = 0; k < ne; k++) if (bad < 0 && obs[k] !== exp[k]) bad = k;
            check(bad < 0, req, "stream byte", (bad < 0) ? 0 : obs[bad], (bad < 0) ? 0 : exp[bad]);
        end
        if (ins) begin
            check(nerr == 0, "R10", "err pulses in insert", nerr, 0);
            check(nstall == 8, "R10", "stall cycles", nstall, 8);
        end else begin
            check(nerr == 1, "R4", "err pulses", nerr, 1);
            check(eg == xg, req, "err_guard", eg, xg);
            check(er == xr, req, "err_ref", er, xr);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(err_valid == 1'b0, "R1", "err_valid", err_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);

        // R2 R3 R6 R12: pass mode, type 1, clean sectors with a stepping reference
        cfg_mode = 2'd0; cfg_type = 2'd1; cfg_app = 16'h1234;
        pulse_start(32'd100);
        for (int s = 0; s < 12; s++) begin
            d = 32'hA5C30F00 + s * 32'h01030507;
            do_sector(d, crc_of(d), 16'h1000 + 16'(s), 32'd100 + 32'(s), 16'hBE00 + 16'(s), 0, 0, "R2");
        end
        // R5: corrupted guard
        d = 32'h00000000;
        do_sector(d, crc_of(d) ^ 16'h0001, 16'h0, 32'd112, 16'h0101, 1, 0, "R5");
        d = 32'hFFFFFFFF;
        do_sector(d, crc_of(d) ^ 16'h8000, 16'h0, 32'd113, 16'h0202, 1, 0, "R5");
        // R6: wrong reference under type 1
        d = 32'h13579BDF;
        do_sector(d, crc_of(d), 16'h0, 32'd999, 16'h0303, 0, 1, "R6");
        // R7: application escape suppresses both flags
        d = 32'h2468ACE0;
        do_sector(d, ~crc_of(d), 16'hFFFF, 32'd7, 16'h0404, 0, 0, "R7");
        // R8: reference escape suppresses both flags
        d = 32'h11223344;
        do_sector(d, ~crc_of(d), 16'h5555, 32'hFFFFFFFF, 16'h0505, 0, 0, "R8");
        // R6: reference still stepping after these sectors (12+5 = 17)
        d = 32'hCAFEF00D;
        do_sector(d, crc_of(d), 16'h0, 32'd117, 16'h0606, 0, 0, "R6");

        // R6: type 2 fixed reference
        cfg_type = 2'd2;
        pulse_start(32'h55AA);
        for (int s = 0; s < 3; s++) begin
            d = 32'h10203040 * (s + 1);
            do_sector(d, crc_of(d), 16'h0, 32'h55AA, 16'h0707, 0, 0, "R6");
        end
        d = 32'h0BADCAFE;
        do_sector(d, crc_of(d), 16'h0, 32'h55AB, 16'h0808, 0, 1, "R6");

        // R6: type 3 never checks the reference, guard still checked
        cfg_type = 2'd3;
        d = 32'h31415926;
        do_sector(d, crc_of(d), 16'h0, 32'hDEADBEEF, 16'h0909, 0, 0, "R6");
        do_sector(d, crc_of(d) ^ 16'h0100, 16'h0, 32'h1, 16'h0A0A, 1, 0, "R6");

        // R9 R12: strip mode, type 1
        cfg_mode = 2'd2; cfg_type = 2'd1;
        pulse_start(32'd7);
        for (int s = 0; s < 3; s++) begin
            d = 32'h77665544 ^ (32'(s) << 8);
            do_sector(d, crc_of(d), 16'hABCD, 32'd7 + 32'(s), 16'hC0DE, 0, 0, "R9");
        end
        d = 32'h99887766;
        do_sector(d, crc_of(d) ^ 16'h0002, 16'h0, 32'd10, 16'hC0DF, 1, 0, "R9");
        do_sector(d, crc_of(d), 16'h0, 32'd0, 16'hC0E0, 0, 1, "R9");

        // R10 R3: insert mode, type 1 then type 2
        cfg_mode = 2'd1; cfg_app = 16'h4A7B;
        pulse_start(32'h200);
        for (int s = 0; s < 4; s++) begin
            d = 32'h5A5A0000 + 32'(s * 77);
            do_sector(d, 16'h0, 16'h0, 32'h200 + 32'(s), 16'hE000 + 16'(s), 0, 0, "R10");
        end
        cfg_type = 2'd2;
        pulse_start(32'h0F0F0F0F);
        d = 32'h01020304;
        do_sector(d, 16'h0, 16'h0, 32'h0F0F0F0F, 16'hE100, 0, 0, "R10");

        // R11: start in mid-sector realigns and reseeds
        cfg_mode = 2'd0; cfg_type = 2'd1;
        put(8'h12); put(8'h34);
        pulse_start(32'd5000);
        d = 32'hFEDCBA98;
        do_sector(d, crc_of(d), 16'h0, 32'd5000, 16'h1111, 0, 0, "R11");
        do_sector(d, crc_of(d), 16'h0, 32'd5001, 16'h2222, 0, 0, "R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule